// File: doc/BRIEF.md
# Power Threshold Monitor and Throttle Controller

This block watches a power reading for an accelerator card, given in whole watts, and compares it with two thresholds that software programs. Each comparison drives a live alarm bit. The two alarms together select a throttle level: none, moderate (50%) or heavy (90%). A separate actuator carries out the throttling.

The block also reports two other kinds of status. The first is a latency-tolerance flag, which is the AND of one "tolerates at least 40 µs memory latency" input per accelerated function unit. The second is a pair of power limits, one for the host processor and one for the accelerator. Each limit is a 0.1 W field with an enable flag, and it is captured from input pins.

Software reaches the block through a 64-bit register port. Reads return their data one cycle after the request. Writes use byte enables, so each threshold can be changed on its own.

Top module: `pwr_mon_top`

## Requirements
- R1: After reset both thresholds read 127, both limit words read zero with the enable flag clear, and throttle_o is 2'b00.
- R2: A read of offset 0x08 returns the registered power sample in bits 17:0 and the latency-tolerance flag in bit 18. All other bits are zero.
- R3: Offset 0x10 holds threshold1 in bits 6:0 and threshold2 in bits 14:8. A write with byte-enable bit 0 updates threshold1 only, and a write with byte-enable bit 1 updates threshold2 only. The threshold that is not enabled keeps its value.
- R4: Bit 16 of offset 0x10 reads 1 exactly when the sample is at or above threshold1. Bit 17 reads 1 exactly when the sample is at or above threshold2.
- R5: Writes to offset 0x10 never change bits 16 and 17, nor bits 7 and 15, as read back. The alarms follow the sample only.
- R6: throttle_o is 2'b10 whenever the sample is at or above threshold2. Otherwise it is 2'b01 when the sample is at or above threshold1, and 2'b00 in all other cases. The code 2'b11 never appears.
- R7: Offset 0x18 returns the host limit and offset 0x20 returns the accelerator limit. Each word has the 15-bit limit in bits 14:0 and the enable flag in bit 15, captured from the pins. Writes to these offsets have no effect.
- R8: A read of any other offset returns zero. A write to any other offset changes no register.
- R9: rd_valid_o pulses high in the cycle after each cycle with rd_en_i high, and only then. rd_data_o is valid in that same cycle.
- R10: The latency-tolerance bit is 0 if any unit's afu_lat_ok_i bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 64 | Write data |
| wr_be_i | input | 8 | Write byte enables |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 64 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| pwr_i | input | 18 | Power sample in whole watts |
| afu_lat_ok_i | input | 4 | Per-unit latency tolerance flags |
| host_lim_i | input | 15 | Host power limit, 0.1 W units |
| host_lim_en_i | input | 1 | Host limit enable |
| acc_lim_i | input | 15 | Accelerator power limit, 0.1 W units |
| acc_lim_en_i | input | 1 | Accelerator limit enable |
| throttle_o | output | 2 | Throttle level: 00 none, 01 moderate, 10 heavy |

## Verification
The bench drives the sample exactly onto each threshold and one watt below it. A design that compares with a strict greater-than would miss the alarm at equality and leave the throttle one level too low.

The bench programs threshold2 below threshold1 and sets threshold1 to zero. Under that inversion, a wrong priority would pick moderate where heavy is required, and a zero threshold must raise its alarm even when the sample is zero.

Single-lane writes, whose data also carries ones in the alarm and padding bits, show up any design that overwrites the neighbouring threshold or lets written alarm bits stick. Reads of unmapped and misaligned offsets, followed by a write of all ones to an unmapped offset and a read-back of the thresholds and limits, catch a loose address decode.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;
  typedef enum logic [1:0] {
    THR_NONE  = 2'b00,
    THR_MOD   = 2'b01,
    THR_HEAVY = 2'b10
  } throttle_e;

  localparam int OFS_STATUS = 8'h08;
  localparam int OFS_THR    = 8'h10;
  localparam int OFS_HLIM   = 8'h18;
  localparam int OFS_ALIM   = 8'h20;

  localparam int THR1_LSB = 0;
  localparam int THR2_LSB = 8;
  localparam int ALM1_BIT = 16;
  localparam int ALM2_BIT = 17;
  localparam int LAT_BIT  = 18;
  localparam int LIM_EN_BIT = 15;
  localparam int NUM_THR  = 2;
  localparam int NUM_LIM  = 2;
endpackage

// File: rtl/pwr_thr_regs.sv
module pwr_thr_regs
  import pwr_mon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  parameter int THR_W  = 7,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [BE_W-1:0]            wr_be_i,
  output logic [NUM_THR*THR_W-1:0]   thr_o
);
  localparam int THR_STRIDE = THR2_LSB - THR1_LSB;

  logic sel;
  logic unused_wr_bits;
  assign sel = wr_en_i && (wr_addr_i == ADDR_W'(OFS_THR));
  assign unused_wr_bits = ^wr_data_i;

  // one byte lane per threshold; lane g holds threshold g+1
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic [THR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= '1;
      else if (sel && wr_be_i[g])    q <= wr_data_i[THR1_LSB + g*THR_STRIDE +: THR_W];
    end
    assign thr_o[g*THR_W +: THR_W] = q;
  end

  a_r3_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> $stable(thr_o));
  a_r3_lane0_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !wr_be_i[1]) |=> $stable(thr_o[THR_W +: THR_W]));
  a_r3_lane1_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !wr_be_i[0]) |=> $stable(thr_o[0 +: THR_W]));
endmodule

// File: rtl/pwr_alarm.sv
module pwr_alarm
  import pwr_mon_pkg::*;
#(
  parameter int PWR_W = 18,
  parameter int THR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [THR_W-1:0] thr1_i,
  input  logic [THR_W-1:0] thr2_i,
  output logic [PWR_W-1:0] pwr_q_o,
  output logic [1:0]       alarm_o,
  output throttle_e        throttle_o
);
  logic [PWR_W-1:0] pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= '0;
    else         pwr_q <= pwr_i;
  end

  assign alarm_o[0] = pwr_q >= PWR_W'(thr1_i);
  assign alarm_o[1] = pwr_q >= PWR_W'(thr2_i);
  assign pwr_q_o    = pwr_q;

  // heavy wins even if threshold2 was programmed below threshold1
  always_comb begin
    if (alarm_o[1])      throttle_o = THR_HEAVY;
    else if (alarm_o[0]) throttle_o = THR_MOD;
    else                 throttle_o = THR_NONE;
  end

  a_r6_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_o != 2'b11);
endmodule

// File: rtl/pwr_csr_rd.sv
module pwr_csr_rd
  import pwr_mon_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 64,
  parameter int PWR_W   = 18,
  parameter int THR_W   = 7,
  parameter int LIM_W   = 15,
  parameter int NUM_AFU = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic [PWR_W-1:0]         pwr_q_i,
  input  logic [1:0]               alarm_i,
  input  logic [NUM_THR*THR_W-1:0] thr_i,
  input  logic [NUM_AFU-1:0]       afu_lat_ok_i,
  input  logic [NUM_LIM*LIM_W-1:0] lim_i,
  input  logic [NUM_LIM-1:0]       lim_en_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_valid_o
);
  logic                      lat_q;
  logic [NUM_LIM*DATA_W-1:0] lim_word;
  logic [DATA_W-1:0]         stat_word, thr_word, rd_mux;
  logic                      unmapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 1'b0;
    else         lat_q <= &afu_lat_ok_i;
  end

  // channel 0: host limit, channel 1: accelerator limit
  for (genvar c = 0; c < NUM_LIM; c++) begin : g_lim
    logic [LIM_W-1:0] lim_q;
    logic             en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lim_q <= '0;
        en_q  <= 1'b0;
      end else begin
        lim_q <= lim_i[c*LIM_W +: LIM_W];
        en_q  <= lim_en_i[c];
      end
    end
    always_comb begin
      lim_word[c*DATA_W +: DATA_W]                = '0;
      lim_word[c*DATA_W +: LIM_W]                 = lim_q;
      lim_word[c*DATA_W + LIM_EN_BIT]             = en_q;
    end
  end

  always_comb begin
    stat_word                 = '0;
    stat_word[PWR_W-1:0]      = pwr_q_i;
    stat_word[LAT_BIT]        = lat_q;
    thr_word                  = '0;
    thr_word[THR1_LSB +: THR_W] = thr_i[0 +: THR_W];
    thr_word[THR2_LSB +: THR_W] = thr_i[THR_W +: THR_W];
    thr_word[ALM1_BIT]        = alarm_i[0];
    thr_word[ALM2_BIT]        = alarm_i[1];
  end

  assign unmapped = !(rd_addr_i == ADDR_W'(OFS_STATUS) || rd_addr_i == ADDR_W'(OFS_THR) ||
                      rd_addr_i == ADDR_W'(OFS_HLIM)   || rd_addr_i == ADDR_W'(OFS_ALIM));

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == ADDR_W'(OFS_STATUS))    rd_mux = stat_word;
    else if (rd_addr_i == ADDR_W'(OFS_THR))  rd_mux = thr_word;
    else if (rd_addr_i == ADDR_W'(OFS_HLIM)) rd_mux = lim_word[0 +: DATA_W];
    else if (rd_addr_i == ADDR_W'(OFS_ALIM)) rd_mux = lim_word[DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && unmapped) |=> rd_data_o == '0);
endmodule

// File: rtl/pwr_mon_top.sv
module pwr_mon_top
  import pwr_mon_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 64,
  parameter int PWR_W   = 18,
  parameter int THR_W   = 7,
  parameter int LIM_W   = 15,
  parameter int NUM_AFU = 4,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic [PWR_W-1:0]  pwr_i,
  input  logic [NUM_AFU-1:0] afu_lat_ok_i,
  input  logic [LIM_W-1:0]  host_lim_i,
  input  logic              host_lim_en_i,
  input  logic [LIM_W-1:0]  acc_lim_i,
  input  logic              acc_lim_en_i,
  output logic [1:0]        throttle_o
);
  logic [NUM_THR*THR_W-1:0] thr;
  logic [PWR_W-1:0]         pwr_q;
  logic [1:0]               alarm;
  throttle_e                thr_lvl;

  pwr_thr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .wr_be_i,
    .thr_o(thr)
  );

  pwr_alarm #(.PWR_W(PWR_W), .THR_W(THR_W)) u_alarm (
    .clk_i, .rst_ni, .pwr_i,
    .thr1_i(thr[0 +: THR_W]), .thr2_i(thr[THR_W +: THR_W]),
    .pwr_q_o(pwr_q), .alarm_o(alarm), .throttle_o(thr_lvl)
  );

  pwr_csr_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_W(PWR_W), .THR_W(THR_W),
               .LIM_W(LIM_W), .NUM_AFU(NUM_AFU)) u_rd (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i,
    .pwr_q_i(pwr_q), .alarm_i(alarm), .thr_i(thr), .afu_lat_ok_i,
    .lim_i({acc_lim_i, host_lim_i}), .lim_en_i({acc_lim_en_i, host_lim_en_i}),
    .rd_data_o, .rd_valid_o
  );

  assign throttle_o = thr_lvl;

  a_r6_heavy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q >= PWR_W'(thr[THR_W +: THR_W])) |-> throttle_o == 2'b10);
  a_r6_moderate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q >= PWR_W'(thr[0 +: THR_W]) && pwr_q < PWR_W'(thr[THR_W +: THR_W]))
      |-> throttle_o == 2'b01);
  a_r6_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q < PWR_W'(thr[0 +: THR_W]) && pwr_q < PWR_W'(thr[THR_W +: THR_W]))
      |-> throttle_o == 2'b00);
endmodule

// File: tb/tb_pwr_mon_top.sv
module tb_pwr_mon_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [7:0]  wr_be_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_valid_o;
  logic [17:0] pwr_i = '0;
  logic [3:0]  afu_lat_ok_i = '0;
  logic [14:0] host_lim_i = '0;
  logic        host_lim_en_i = 1'b0;
  logic [14:0] acc_lim_i = '0;
  logic        acc_lim_en_i = 1'b0;
  logic [1:0]  throttle_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  pwr_mon_top dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rd_valid", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_be_i = be;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0;
  endtask

  function automatic logic [1:0] exp_thr(input int p, input int t1, input int t2);
    if (p >= t2) return 2'b10;
    if (p >= t1) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [63:0] thr_word(input int p, input int t1, input int t2);
    logic [63:0] w = '0;
    w[6:0]  = 7'(t1);
    w[14:8] = 7'(t2);
    w[16]   = (p >= t1);
    w[17]   = (p >= t2);
    return w;
  endfunction

  task automatic set_pwr_chk(input int p, input int t1, input int t2, input string tag);
    @(negedge clk_i);
    pwr_i = 18'(p);
    @(negedge clk_i);
    check(tag, {62'd0, throttle_o}, {62'd0, exp_thr(p, t1, t2)});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 throttle after reset", {62'd0, throttle_o}, 64'd0);
    do_read(8'h10, 64'h7F7F, "R1 thresholds at reset");
    do_read(8'h18, 64'h0, "R1 host limit at reset");
    do_read(8'h20, 64'h0, "R1 acc limit at reset");

    // limits
    host_lim_i = 15'h1234; host_lim_en_i = 1'b1;
    acc_lim_i = 15'h7FFF;  acc_lim_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    do_read(8'h18, 64'h9234, "R7 host limit word");
    do_read(8'h20, 64'h7FFF, "R7 acc limit word");
    do_write(8'h18, '1, 8'hFF);
    do_write(8'h20, '0, 8'hFF);
    do_read(8'h18, 64'h9234, "R7 host limit write ignored");
    do_read(8'h20, 64'h7FFF, "R7 acc limit write ignored");

    // status
    afu_lat_ok_i = 4'hF;
    set_pwr_chk(18'h2ABCD, 127, 127, "R6 heavy at default thresholds");
    do_read(8'h08, 64'h6ABCD, "R2 status with latency ok");
    afu_lat_ok_i = 4'b1101;
    repeat (2) @(negedge clk_i);
    do_read(8'h08, 64'h2ABCD, "R10 one unit latency sensitive");

    // lane write: threshold1 only, junk in other bytes
    do_write(8'h10, 64'h0003_1128, 8'h01);
    set_pwr_chk(50, 40, 127, "R3 thr1 only, throttle moderate");
    do_read(8'h10, thr_word(50, 40, 127), "R3 thr1 updated thr2 kept");

    // full write with alarm and padding bits set
    do_write(8'h10, 64'h0003_DAC6, 8'hFF);
    set_pwr_chk(50, 70, 90, "R6 below both");
    do_read(8'h10, thr_word(50, 70, 90), "R5 alarm and pad bits not written");
    set_pwr_chk(69, 70, 90, "R4 one below thr1");
    set_pwr_chk(70, 70, 90, "R4 equal thr1");
    do_read(8'h10, thr_word(70, 70, 90), "R4 alarm1 at equality");
    set_pwr_chk(89, 70, 90, "R4 one below thr2");
    set_pwr_chk(90, 70, 90, "R6 equal thr2 heavy");
    do_read(8'h10, thr_word(90, 70, 90), "R4 both alarms");
    set_pwr_chk(200, 70, 90, "R6 far above");

    // inverted thresholds: thr2 below thr1
    do_write(8'h10, 64'h0000_1400, 8'h02);
    set_pwr_chk(50, 70, 20, "R6 heavy priority inverted");
    do_read(8'h10, thr_word(50, 70, 20), "R3 thr2 only updated");

    // zero threshold1
    do_write(8'h10, 64'h0, 8'h01);
    set_pwr_chk(0, 0, 20, "R4 zero threshold at zero sample");
    do_read(8'h10, thr_word(0, 0, 20), "R4 zero threshold alarm word");

    // unmapped
    do_read(8'h28, 64'h0, "R8 unmapped read 0x28");
    do_read(8'h00, 64'h0, "R8 unmapped read 0x00");
    do_read(8'h11, 64'h0, "R8 misaligned read 0x11");
    do_write(8'h30, '1, 8'hFF);
    do_write(8'h11, '1, 8'hFF);
    do_read(8'h10, thr_word(0, 0, 20), "R8 unmapped write no effect thr");
    do_read(8'h18, 64'h9234, "R8 unmapped write no effect limit");

    repeat (3) @(negedge clk_i);
    check("R9 every read answered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule